// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Controller

The block gathers seven interrupt request lines, one per priority level from 1 to 7. It compares them with a 3-bit processor mask and presents the highest pending level on a 3-bit output. Each line is set for level or edge sensitivity. An edge-sensitive line is latched on its rising edge and stays pending until it is acknowledged. A level-sensitive line counts only while it is held high. Level 7 ignores the mask. While its line stays high it requests only once, and it must be negated and raised again before it can request again.

When the processor runs an acknowledge cycle, the block reads the acknowledged level from address bits 3 to 1. There are three outcomes. If that level has no live request, the block pulses a spurious indication and gives no other response. If the level is autovectored, by its configuration bit or by the external autovector input, the block ends the cycle itself in the next clock. It returns vector 24 plus the level and never strobes the external devices. In every other case it strobes the devices and waits for one of them to answer. The vector is then taken from the low byte of the device data bus.

Top module: `irq_ack_ctrl`

## Requirements
- R1: After reset, `ipl_o` is 0, `dev_iack_o`, `ack_done_o`, `autovec_o` and `spurious_o` are all 0, and a level-7 line in level mode is armed.
- R2: For each line n (bit n-1 of `irq_i`, level n) in level mode, the request is live while the line is high. It is pending when n > `mask_i`. `ipl_o` is the highest pending level, or 0 when no level is pending, and it follows a change of `irq_i` one clock later.
- R3: A line in edge mode (`edge_mode_i` bit = 1) latches its rising edge, even when the line is high for only one clock. The request stays live after the line falls, until that level is acknowledged.
- R4: Level 7 is pending whatever the mask. After an acknowledge of level 7, a line that stays high is not live. It becomes live again one clock after the line is seen low and then high again.
- R5: An acknowledge (`iack_i` high for one clock) takes its level from `iack_addr_i[3:1]`. If that level is live and autovectored (`avec_cfg_i` bit = 1, or `ext_avec_i` = 1), then in the next clock `ack_done_o` = 1, `autovec_o` = 1 and `vec_o` = 24 + level, and `dev_iack_o` stays 0.
- R6: If the acknowledged level is live and not autovectored, `dev_iack_o` rises in the next clock and stays high until `dev_ack_i` is sampled. In the clock after that, `ack_done_o` = 1, `autovec_o` = 0 and `vec_o` = `dev_data_i[7:0]`.
- R7: If the acknowledged level is 0, or has no live request, `spurious_o` pulses for exactly one clock, and `ack_done_o` and `dev_iack_o` stay 0. This covers a level-sensitive line that was removed and an autovectored level with no request.
- R8: An acknowledge that arrives while the block is waiting for a device is ignored. It gives no spurious pulse and does not end the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 7 | Request lines, bit n-1 is level n, active high |
| edge_mode_i | input | 7 | Per line: 1 = edge sensitive, 0 = level sensitive |
| avec_cfg_i | input | 7 | Per level: 1 = end the acknowledge internally |
| mask_i | input | 3 | Processor interrupt mask |
| ipl_o | output | 3 | Highest pending level, 0 = none |
| iack_i | input | 1 | Acknowledge cycle strobe, one clock |
| iack_addr_i | input | 4 | Acknowledge address, level in bits 3:1 |
| ext_avec_i | input | 1 | External autovector request for this acknowledge |
| dev_iack_o | output | 1 | Acknowledge strobe to external devices |
| dev_ack_i | input | 1 | Device has placed its vector on the data bus |
| dev_data_i | input | 16 | Device data bus, vector in bits 7:0 |
| ack_done_o | output | 1 | Acknowledge completed, pulse |
| autovec_o | output | 1 | Completion was internal (autovector) |
| spurious_o | output | 1 | Acknowledge found no live request, pulse |
| vec_o | output | 8 | Vector number of the last completed acknowledge |

## Verification
There are two ways an edge latch or the level-7 arm flag can go wrong. A latch that is lost, or an arm flag that is never cleared, shows on `ipl_o` one clock after the related input event. A latch or flag that is never released shows up in the same way. A bad live decode shows up in the very next clock as the wrong kind of response, a spurious pulse in place of a completion or the reverse. A sequencer stuck in its device wait keeps `dev_iack_o` high, so later acknowledges never complete.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_st_t;
endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int NLVL = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] irq_i,
  input  logic [NLVL-1:0] edge_mode_i,
  input  logic [NLVL-1:0] ack_clr_i,
  output logic [NLVL-1:0] live_o
);
  logic [NLVL-1:0] irq_q;
  logic [NLVL-1:0] pend_q, pend_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_i;
  end

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    logic rise;
    assign rise = irq_i[g] & ~irq_q[g];

    always_comb begin
      pend_d[g] = pend_q[g];
      if (ack_clr_i[g]) pend_d[g] = 1'b0;
      if (rise && edge_mode_i[g]) pend_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end

    if (g == NLVL - 1) begin : g_nmi
      logic arm_q, arm_d;
      always_comb begin
        arm_d = arm_q;
        if (!irq_q[g])    arm_d = 1'b1;
        if (ack_clr_i[g]) arm_d = 1'b0;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b1;
        else        arm_q <= arm_d;
      end
      assign live_o[g] = edge_mode_i[g] ? pend_q[g] : (irq_q[g] & arm_q);
    end else begin : g_std
      assign live_o[g] = edge_mode_i[g] ? pend_q[g] : irq_q[g];
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int NLVL  = 7,
  parameter int LVL_W = 3
) (
  input  logic [NLVL-1:0]  live_i,
  input  logic [LVL_W-1:0] mask_i,
  output logic [LVL_W-1:0] ipl_o
);
  always_comb begin
    ipl_o = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (live_i[i] && ((LVL_W'(i + 1) > mask_i) || (i == NLVL - 1)))
        ipl_o = LVL_W'(i + 1);
    end
  end
endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import irq_ack_pkg::*;
#(
  parameter int NLVL    = 7,
  parameter int LVL_W   = 3,
  parameter int DATA_W  = 16,
  parameter int VEC_W   = 8,
  parameter int AV_BASE = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iack_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [NLVL-1:0]   live_i,
  input  logic [NLVL-1:0]   avec_cfg_i,
  input  logic              ext_avec_i,
  input  logic              dev_ack_i,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic [NLVL-1:0]   ack_clr_o,
  output logic              dev_iack_o,
  output logic              ack_done_o,
  output logic              autovec_o,
  output logic              spurious_o,
  output logic [VEC_W-1:0]  vec_o
);
  seq_st_t          st_q, st_d;
  logic             done_d, av_d, spur_d;
  logic [VEC_W-1:0] vec_d;
  logic             sel_live, sel_av, accept;

  always_comb begin
    sel_live = 1'b0;
    sel_av   = ext_avec_i;
    for (int i = 0; i < NLVL; i++) begin
      if (lvl_i == LVL_W'(i + 1)) begin
        sel_live = live_i[i];
        sel_av   = sel_av | avec_cfg_i[i];
      end
    end
  end

  assign accept = iack_i && (st_q == SEQ_IDLE);

  always_comb begin
    for (int i = 0; i < NLVL; i++)
      ack_clr_o[i] = accept && (lvl_i == LVL_W'(i + 1));
  end

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    av_d   = 1'b0;
    spur_d = 1'b0;
    vec_d  = vec_o;
    case (st_q)
      SEQ_IDLE: begin
        if (accept) begin
          if (!sel_live) begin
            spur_d = 1'b1;
          end else if (sel_av) begin
            done_d = 1'b1;
            av_d   = 1'b1;
            vec_d  = VEC_W'(AV_BASE) + VEC_W'(lvl_i);
          end else begin
            st_d = SEQ_WAIT;
          end
        end
      end
      SEQ_WAIT: begin
        if (dev_ack_i) begin
          st_d   = SEQ_IDLE;
          done_d = 1'b1;
          vec_d  = dev_data_i[VEC_W-1:0];
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SEQ_IDLE;
      ack_done_o <= 1'b0;
      autovec_o  <= 1'b0;
      spurious_o <= 1'b0;
      vec_o      <= '0;
    end else begin
      st_q       <= st_d;
      ack_done_o <= done_d;
      autovec_o  <= av_d;
      spurious_o <= spur_d;
      vec_o      <= vec_d;
    end
  end

  assign dev_iack_o = (st_q == SEQ_WAIT);
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int NLVL    = 7,
  parameter int DATA_W  = 16,
  parameter int VEC_W   = 8,
  parameter int AV_BASE = 24,
  localparam int LVL_W  = $clog2(NLVL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   irq_i,
  input  logic [NLVL-1:0]   edge_mode_i,
  input  logic [NLVL-1:0]   avec_cfg_i,
  input  logic [LVL_W-1:0]  mask_i,
  output logic [LVL_W-1:0]  ipl_o,
  input  logic              iack_i,
  input  logic [LVL_W:0]    iack_addr_i,
  input  logic              ext_avec_i,
  output logic              dev_iack_o,
  input  logic              dev_ack_i,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic              ack_done_o,
  output logic              autovec_o,
  output logic              spurious_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [NLVL-1:0] live;
  logic [NLVL-1:0] ack_clr;

  irq_capture #(.NLVL(NLVL)) u_cap (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .edge_mode_i(edge_mode_i),
    .ack_clr_i(ack_clr), .live_o(live)
  );

  irq_prio #(.NLVL(NLVL), .LVL_W(LVL_W)) u_prio (
    .live_i(live), .mask_i(mask_i), .ipl_o(ipl_o)
  );

  iack_seq #(
    .NLVL(NLVL), .LVL_W(LVL_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .AV_BASE(AV_BASE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .iack_i(iack_i), .lvl_i(iack_addr_i[LVL_W:1]),
    .live_i(live), .avec_cfg_i(avec_cfg_i), .ext_avec_i(ext_avec_i),
    .dev_ack_i(dev_ack_i), .dev_data_i(dev_data_i), .ack_clr_o(ack_clr),
    .dev_iack_o(dev_iack_o), .ack_done_o(ack_done_o), .autovec_o(autovec_o),
    .spurious_o(spurious_o), .vec_o(vec_o)
  );
endmodule

// File: rtl/irq_ack_ctrl_chk.sv
module irq_ack_ctrl_chk #(
  parameter int NLVL   = 7,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 8,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLVL-1:0]   irq_i,
  input logic [NLVL-1:0]   edge_mode_i,
  input logic [NLVL-1:0]   avec_cfg_i,
  input logic [LVL_W-1:0]  mask_i,
  input logic [LVL_W-1:0]  ipl_o,
  input logic              iack_i,
  input logic [LVL_W:0]    iack_addr_i,
  input logic              ext_avec_i,
  input logic              dev_iack_o,
  input logic              dev_ack_i,
  input logic [DATA_W-1:0] dev_data_i,
  input logic              ack_done_o,
  input logic              autovec_o,
  input logic              spurious_o,
  input logic [VEC_W-1:0]  vec_o
);
  // R2
  mask_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ipl_o != '0 && ipl_o != LVL_W'(NLVL)) |-> (ipl_o > mask_i));

  // R7
  spur_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious_o |-> (!ack_done_o && !dev_iack_o));

  // R7
  spur_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spurious_o |-> $past(iack_i));

  // R5
  av_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done_o && autovec_o) |-> (vec_o[VEC_W-1:3] == 5'b00011 && $past(!dev_iack_o)));

  // R5
  av_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    autovec_o |-> ack_done_o);

  // R6
  dev_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_done_o && !autovec_o) |->
      ($past(dev_ack_i && dev_iack_o) && vec_o == $past(dev_data_i[VEC_W-1:0])));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_iack_o && !dev_ack_i) |=> (dev_iack_o && !spurious_o));
endmodule

bind irq_ack_ctrl irq_ack_ctrl_chk #(
  .NLVL(NLVL), .DATA_W(DATA_W), .VEC_W(VEC_W), .LVL_W(LVL_W)
) chk_i (.*);

// File: tb/irq_ack_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ack_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic [6:0] irq_i, edge_mode_i, avec_cfg_i;
  logic [2:0] mask_i, ipl_o;
  logic iack_i, ext_avec_i, dev_iack_o, dev_ack_i;
  logic [3:0] iack_addr_i;
  logic [15:0] dev_data_i;
  logic ack_done_o, autovec_o, spurious_o;
  logic [7:0] vec_o;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_ack_ctrl dut_i (.*);

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_iack(int lvl);
    iack_i = 1'b1;
    iack_addr_i = {lvl[2:0], 1'b0};
    step();
    iack_i = 1'b0;
  endtask

  function automatic int exp_ipl(int pat, int m);
    int r = 0;
    for (int l = 1; l <= 7; l++)
      if (pat[l-1] && (l > m || l == 7)) r = l;
    return r;
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_i = '0; edge_mode_i = '0; avec_cfg_i = '0; mask_i = '0;
    iack_i = 1'b0; iack_addr_i = '0; ext_avec_i = 1'b0; dev_ack_i = 1'b0;
    dev_data_i = '0;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 ipl", ipl_o, 0);
    check("R1 dev_iack", dev_iack_o, 0);
    check("R1 pulses", {ack_done_o, autovec_o, spurious_o}, 0);

    // R2 sweep all patterns and masks, level mode (R4 level 7 ignores mask)
    for (int m = 0; m < 8; m++) begin
      for (int p = 0; p < 128; p++) begin
        mask_i = m[2:0];
        irq_i = p[6:0];
        step();
        check(((p & 64) != 0 && m == 7) ? "R4 nmi" : "R2 prio", ipl_o, exp_ipl(p, m));
      end
    end
    irq_i = '0; mask_i = '0;
    step();
    check("R2 idle", ipl_o, 0);

    // R3 edge capture of a one-clock pulse on level 3, then R5 autovector by register
    edge_mode_i = 7'b0000100;
    avec_cfg_i  = 7'b0000100;
    irq_i[2] = 1'b1;
    step();
    irq_i[2] = 1'b0;
    step();
    check("R3 held", ipl_o, 3);
    step();
    check("R3 still held", ipl_o, 3);
    do_iack(3);
    check("R5 done", ack_done_o, 1);
    check("R5 autovec", autovec_o, 1);
    check("R5 vec", vec_o, 27);
    check("R5 no dev strobe", dev_iack_o, 0);
    check("R3 cleared", ipl_o, 0);
    step();
    check("R5 one pulse", ack_done_o, 0);
    edge_mode_i = '0; avec_cfg_i = '0;

    // R6 device-supplied vector on level 5, with R8 ignored acknowledge while waiting
    irq_i[4] = 1'b1;
    step();
    check("R2 lvl5", ipl_o, 5);
    do_iack(5);
    check("R6 strobe", dev_iack_o, 1);
    check("R6 not done", ack_done_o, 0);
    do_iack(2);
    check("R8 no spurious", spurious_o, 0);
    check("R8 still waiting", dev_iack_o, 1);
    dev_ack_i = 1'b1; dev_data_i = 16'hAB40;
    step();
    dev_ack_i = 1'b0;
    check("R6 done", ack_done_o, 1);
    check("R6 autovec", autovec_o, 0);
    check("R6 vec", vec_o, 8'h40);
    check("R6 strobe off", dev_iack_o, 0);
    irq_i[4] = 1'b0;
    step();

    // R7 withdrawn level-sensitive request
    irq_i[3] = 1'b1;
    step();
    irq_i[3] = 1'b0;
    step();
    do_iack(4);
    check("R7 withdrawn spurious", spurious_o, 1);
    check("R7 withdrawn done", ack_done_o, 0);
    check("R7 withdrawn strobe", dev_iack_o, 0);
    step();
    check("R7 one pulse", spurious_o, 0);
    // R7 autovectored level with no request
    ext_avec_i = 1'b1;
    do_iack(2);
    ext_avec_i = 1'b0;
    check("R7 avec spurious", spurious_o, 1);
    check("R7 avec done", ack_done_o, 0);
    // R7 level 0
    do_iack(0);
    check("R7 lvl0 spurious", spurious_o, 1);

    // R4 level 7 re-arm
    mask_i = 3'd7;
    irq_i[6] = 1'b1;
    step();
    check("R4 pending", ipl_o, 7);
    ext_avec_i = 1'b1;
    do_iack(7);
    ext_avec_i = 1'b0;
    check("R5 nmi vec", vec_o, 31);
    check("R4 disarmed", ipl_o, 0);
    step();
    check("R4 held not live", ipl_o, 0);
    do_iack(7);
    check("R4 held ack spurious", spurious_o, 1);
    irq_i[6] = 1'b0;
    step();
    check("R4 low", ipl_o, 0);
    irq_i[6] = 1'b1;
    step();
    check("R4 rearmed", ipl_o, 7);
    irq_i = '0;
    step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule